// File: doc/BRIEF.md
# I2C write-only audio control slave

This block is the control front end of a stereo volume and tone processor. It watches the two bus lines through synchronizers clocked by the system clock. It recognises START and STOP conditions and accepts write transfers addressed to a fixed 7-bit device address. It acknowledges the address byte and every data byte that follows by pulling SDA low through an open-drain enable.

Every data byte carries its own target, chosen by a prefix of variable length. A clear top bit selects a volume byte. Its lowest bit picks one of the two volume stages, and the remaining bits give a coarse step of 8 dB and a fine step of 1 dB. The top three bits select treble, middle, bass or the input multiplexer. Tone bytes are sign-magnitude, and the highest magnitude is clamped to 14 dB. Decoded values are held in registers that drive the analog path directly. A byte takes effect only once its acknowledge clock has ended. Any number of data bytes may follow one address byte.

The system clock must run at least 16 times faster than SCL. Read transfers and clock stretching are not supported.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: After reset both volumes are muted with attenuation 47, treble, middle and bass are at -14 dB, and the input is active (in_mute_o = 0).
- R2: The address byte 0x86 (address 1000011, write) is acknowledged: sda_pd_o is 1 during the ninth SCL high phase. Any other address byte, including 0x87 (read), is not acknowledged.
- R3: After an accepted address, each of any number of data bytes is acknowledged in its ninth clock.
- R4: A data byte with bit 7 = 0 writes volume stage 1 (bit 0 = 0) or stage 2 (bit 0 = 1). If bits 6..4 are 0 to 5, the attenuation becomes 8*bits[6:4] + bits[3:1] and mute clears. If bits 6..4 are 6 or 7, mute sets and the attenuation becomes 47. The attenuation never exceeds 47.
- R5: Bits 7..5 = 100 write treble, 101 write middle and 110 write bass. The gain is +m when bit 4 = 0 and -m when bit 4 = 1, where m = bits[3:0], with 15 clamped to 14. Gains are two's complement, 5 bits wide.
- R6: Bits 7..5 = 111 address the multiplexer. Low nibble 1111 makes the input active (in_mute_o = 0). Bits[1:0] = 11 with bits[3:2] other than 11 mute the input (in_mute_o = 1). Bits[1:0] equal to 00, 01 or 10 are acknowledged and leave every output unchanged.
- R7: After an address that is not acknowledged, no later byte is acknowledged and no output changes until the next START or STOP.
- R8: A repeated START begins a new address phase, even in the middle of an ignored transfer.
- R9: An output changes only after the acknowledge clock of its byte has ended. A byte cut short by a STOP leaves every output unchanged.
- R10: sda_pd_o is 0 throughout every SCL high phase that carries a data or address bit. It asserts only after a falling edge of SCL, and it releases only at a falling edge of SCL, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (as seen on the wire) |
| sda_pd_o | output | 1 | Open-drain pull-down enable for SDA, 1 = drive low |
| vol1_att_o | output | 6 | Stage 1 attenuation in dB |
| vol1_mute_o | output | 1 | Stage 1 mute |
| vol2_att_o | output | 6 | Stage 2 attenuation in dB |
| vol2_mute_o | output | 1 | Stage 2 mute |
| treble_o | output | 5 | Treble gain in dB, two's complement |
| middle_o | output | 5 | Middle gain in dB, two's complement |
| bass_o | output | 5 | Bass gain in dB, two's complement |
| in_mute_o | output | 1 | Input muted when 1 |

## Verification
The hardest state to reach from the ports is a byte that has been partly shifted in when the transfer ends, because a master that behaves well always finishes its bytes. The bench drives raw bit clocks and issues a STOP after only five bits of a byte that would change the outputs. A second hard case is a repeated START issued while the slave is ignoring the bus. The bench reaches it with a wrong address followed by one data byte, then a repeated START, then the correct address.

// File: rtl/audio_ctrl_pkg.sv
package audio_ctrl_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
  localparam int VOL_W     = 6;
  localparam int TONE_W    = 5;
  localparam int N_VOL     = 2;
  localparam int N_TONE    = 3;
  localparam logic [VOL_W-1:0]  VOL_MUTE_ATT = VOL_W'(47);
  localparam logic [3:0]        TONE_MAG_MAX = 4'd14;
  localparam logic [TONE_W-1:0] TONE_RESET   = TONE_W'(-14);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import audio_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h43
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  localparam logic [7:0]       ADDR_WR  = {DEV_ADDR, 1'b0};
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  phase_e           phase_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [7:0]       shreg_q;
  logic             in_ack_q, pd_q, vld_q;
  logic             active;

  assign active = (phase_q == PH_ADDR) || (phase_q == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      in_ack_q  <= 1'b0;
      pd_q      <= 1'b0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_i || stop_i) begin
        phase_q   <= start_i ? PH_ADDR : PH_IDLE;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        pd_q      <= 1'b0;
      end else if (active) begin
        if (scl_rise_i && !in_ack_q && bit_cnt_q < LAST_BIT) begin
          shreg_q   <= {shreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (scl_fall_i) begin
          if (in_ack_q) begin
            // end of ninth clock: release and commit
            pd_q      <= 1'b0;
            in_ack_q  <= 1'b0;
            bit_cnt_q <= '0;
            if (phase_q == PH_ADDR) phase_q <= PH_DATA;
            else                    vld_q   <= 1'b1;
          end else if (bit_cnt_q == LAST_BIT) begin
            if (phase_q == PH_ADDR && shreg_q != ADDR_WR) begin
              phase_q <= PH_SKIP;
            end else begin
              pd_q     <= 1'b1;
              in_ack_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sda_pd_o   = pd_q;
  assign byte_vld_o = vld_q;
  assign byte_o     = shreg_q;
endmodule

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs
  import audio_ctrl_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic [7:0]                    byte_i,
  output logic [N_VOL-1:0][VOL_W-1:0]   vol_att_o,
  output logic [N_VOL-1:0]              vol_mute_o,
  output logic [N_TONE-1:0][TONE_W-1:0] tone_o,
  output logic                          in_mute_o
);
  logic [2:0]        coarse;
  logic              vol_mute_w;
  logic [VOL_W-1:0]  vol_att_w;
  logic [3:0]        mag;
  logic [TONE_W-1:0] mag_ext, gain_w;
  logic              mux_hit;

  always_comb begin
    coarse     = byte_i[6:4];
    vol_mute_w = coarse >= 3'd6;
    vol_att_w  = vol_mute_w ? VOL_MUTE_ATT : {coarse, byte_i[3:1]};
    mag        = (byte_i[3:0] > TONE_MAG_MAX) ? TONE_MAG_MAX : byte_i[3:0];
    mag_ext    = {1'b0, mag};
    gain_w     = byte_i[4] ? (~mag_ext + 1'b1) : mag_ext;
    mux_hit    = vld_i && (byte_i[7:5] == 3'b111) && (byte_i[1:0] == 2'b11);
  end

  for (genvar v = 0; v < N_VOL; v++) begin : g_vol
    logic hit;
    assign hit = vld_i && !byte_i[7] && (byte_i[0] == v[0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vol_att_o[v]  <= VOL_MUTE_ATT;
        vol_mute_o[v] <= 1'b1;
      end else if (hit) begin
        vol_att_o[v]  <= vol_att_w;
        vol_mute_o[v] <= vol_mute_w;
      end
    end
  end

  // tone index follows bits 6..5: 0 treble, 1 middle, 2 bass
  for (genvar t = 0; t < N_TONE; t++) begin : g_tone
    logic hit;
    assign hit = vld_i && byte_i[7] && (byte_i[6:5] == t[1:0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tone_o[t] <= TONE_RESET;
      else if (hit) tone_o[t] <= gain_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_mute_o <= 1'b0;
    else if (mux_hit) in_mute_o <= (byte_i[3:2] != 2'b11);
  end
endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
  import audio_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h43,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  output logic [VOL_W-1:0]  vol1_att_o,
  output logic              vol1_mute_o,
  output logic [VOL_W-1:0]  vol2_att_o,
  output logic              vol2_mute_o,
  output logic [TONE_W-1:0] treble_o,
  output logic [TONE_W-1:0] middle_o,
  output logic [TONE_W-1:0] bass_o,
  output logic              in_mute_o
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic rx_vld;
  logic [7:0] rx_byte;
  logic [N_VOL-1:0][VOL_W-1:0]   vol_att;
  logic [N_VOL-1:0]              vol_mute;
  logic [N_TONE-1:0][TONE_W-1:0] tone;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  i2c_wr_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .sda_i     (sda_s),
    .sda_pd_o  (sda_pd_o),
    .byte_vld_o(rx_vld),
    .byte_o    (rx_byte)
  );

  audio_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (rx_vld),
    .byte_i    (rx_byte),
    .vol_att_o (vol_att),
    .vol_mute_o(vol_mute),
    .tone_o    (tone),
    .in_mute_o (in_mute_o)
  );

  assign vol1_att_o  = vol_att[0];
  assign vol2_att_o  = vol_att[1];
  assign vol1_mute_o = vol_mute[0];
  assign vol2_mute_o = vol_mute[1];
  assign treble_o    = tone[0];
  assign middle_o    = tone[1];
  assign bass_o      = tone[2];
endmodule

// File: rtl/audio_ctrl_chk.sv
module audio_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_fall_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       commit_i,
  input logic       sda_pd_i,
  input logic [5:0] vol1_att_i,
  input logic       vol1_mute_i,
  input logic [5:0] vol2_att_i,
  input logic       vol2_mute_i,
  input logic [4:0] treble_i,
  input logic [4:0] middle_i,
  input logic [4:0] bass_i,
  input logic       in_mute_i
);
  // R4
  vol_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol1_att_i <= 6'd47 && vol2_att_i <= 6'd47);

  // R4
  mute_att_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol1_mute_i |-> vol1_att_i == 6'd47) and (vol2_mute_i |-> vol2_att_i == 6'd47));

  // R5
  tone_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(treble_i) >= -5'sd14 && $signed(treble_i) <= 5'sd14 &&
    $signed(middle_i) >= -5'sd14 && $signed(middle_i) <= 5'sd14 &&
    $signed(bass_i)   >= -5'sd14 && $signed(bass_i)   <= 5'sd14);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable({vol1_att_i, vol1_mute_i, vol2_att_i, vol2_mute_i,
                           treble_i, middle_i, bass_i, in_mute_i}));

  // R10
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_i) |-> $past(scl_fall_i));

  // R10
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pd_i) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
endmodule

bind audio_ctrl_i2c_slave audio_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall_i (scl_fall),
  .start_i    (bus_start),
  .stop_i     (bus_stop),
  .commit_i   (rx_vld),
  .sda_pd_i   (sda_pd_o),
  .vol1_att_i (vol1_att_o),
  .vol1_mute_i(vol1_mute_o),
  .vol2_att_i (vol2_att_o),
  .vol2_mute_i(vol2_mute_o),
  .treble_i   (treble_o),
  .middle_i   (middle_o),
  .bass_i     (bass_o),
  .in_mute_i  (in_mute_o)
);

// File: tb/audio_ctrl_i2c_slave_bench.sv
module audio_ctrl_i2c_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus, sda_pd;
  logic [5:0] vol1_att, vol2_att;
  logic vol1_mute, vol2_mute, in_mute;
  logic [4:0] treble, middle, bass;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [5:0] e_att [2];
  logic       e_mute[2];
  logic [4:0] e_tone[3];
  logic       e_in_mute;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pd;

  audio_ctrl_i2c_slave u_audio_ctrl_i2c_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pd_o   (sda_pd),
    .vol1_att_o (vol1_att),
    .vol1_mute_o(vol1_mute),
    .vol2_att_o (vol2_att),
    .vol2_mute_o(vol2_mute),
    .treble_o   (treble),
    .middle_o   (middle),
    .bass_o     (bass),
    .in_mute_o  (in_mute)
  );

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [29:0] obs();
    return {vol1_att, vol1_mute, vol2_att, vol2_mute, treble, middle, bass, in_mute};
  endfunction

  function automatic logic [29:0] expv();
    return {e_att[0], e_mute[0], e_att[1], e_mute[1], e_tone[0], e_tone[1], e_tone[2], e_in_mute};
  endfunction

  task automatic chk_outputs(input string tag);
    chk(obs() == expv(), tag, {2'b0, obs()}, {2'b0, expv()});
  endtask

  task automatic model_apply(input logic [7:0] b);
    int c, m;
    if (!b[7]) begin
      c = int'(b[6:4]);
      if (c >= 6) begin
        e_att[b[0]]  = 6'd47;
        e_mute[b[0]] = 1'b1;
      end else begin
        e_att[b[0]]  = 6'(8 * c + int'(b[3:1]));
        e_mute[b[0]] = 1'b0;
      end
    end else if (b[6:5] != 2'b11) begin
      m = int'(b[3:0]);
      if (m > 14) m = 14;
      e_tone[b[6:5]] = b[4] ? 5'(-m) : 5'(m);
    end else if (b[1:0] == 2'b11) begin
      e_in_mute = (b[3:2] != 2'b11);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    wait_q(); sda_m = 1'b0;
    wait_q(); scl_m = 1'b1;
    wait_q(); sda_m = 1'b1;
    wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      wait_q(); sda_m = b[i];
      wait_q(); scl_m = 1'b1;
      wait_q();
      chk(sda_pd == 1'b0, "R10", {31'b0, sda_pd}, 32'h0);
      wait_q(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    send_bits(b, 8);
    wait_q(); sda_m = 1'b1;
    wait_q(); scl_m = 1'b1;
    wait_q();
    chk(sda_pd == exp_ack, tag, {31'b0, sda_pd}, {31'b0, exp_ack});
    wait_q(); scl_m = 1'b0;
    wait_q();
  endtask

  initial begin
    e_att[0] = 6'd47; e_att[1] = 6'd47;
    e_mute[0] = 1'b1; e_mute[1] = 1'b1;
    for (int t = 0; t < 3; t++) e_tone[t] = 5'b10010;
    e_in_mute = 1'b0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_outputs("R1 reset");

    // full sweep of data codes in one transfer
    bus_start();
    send_byte(8'h86, 1'b1, "R2 address ack");
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b;
      string tag;
      b = 8'(d);
      send_byte(b, 1'b1, "R3 data ack");
      model_apply(b);
      if (!b[7])                 tag = "R4 volume";
      else if (b[6:5] != 2'b11)  tag = "R5 tone";
      else                       tag = "R6 mux";
      chk_outputs(tag);
    end
    bus_stop();
    chk_outputs("R6 after stop");

    // read bit set
    bus_start();
    send_byte(8'h87, 1'b0, "R2 read nack");
    bus_stop();

    // wrong address, ignored data, repeated start
    bus_start();
    send_byte(8'h84, 1'b0, "R2 wrong address nack");
    send_byte(8'h22, 1'b0, "R7 ignored byte nack");
    chk_outputs("R7 ignored byte");
    bus_start();
    send_byte(8'h86, 1'b1, "R8 address after repeated start");
    send_byte(8'h22, 1'b1, "R8 data ack");
    model_apply(8'h22);
    send_byte(8'h93, 1'b1, "R8 data ack");
    model_apply(8'h93);
    bus_stop();
    chk(vol1_att == 6'd17 && !vol1_mute, "R8 vol1", {25'b0, vol1_att, vol1_mute}, {25'b0, 6'd17, 1'b0});
    chk(treble == 5'(-3), "R5 treble cut 3", {27'b0, treble}, 32'h1d);
    chk_outputs("R8 outputs");

    // byte cut short by STOP
    bus_start();
    send_byte(8'h86, 1'b1, "R2 address ack");
    send_bits(8'h00, 5);
    bus_stop();
    repeat (20) @(negedge clk);
    chk_outputs("R9 aborted byte");

    // not-allowed mux codes after muting the input
    bus_start();
    send_byte(8'h86, 1'b1, "R2 address ack");
    send_byte(8'hE3, 1'b1, "R3 data ack");
    model_apply(8'hE3);
    chk(in_mute == 1'b1, "R6 mux mute", {31'b0, in_mute}, 32'h1);
    send_byte(8'hEC, 1'b1, "R6 not allowed ack");
    send_byte(8'hFE, 1'b1, "R6 not allowed ack");
    chk(in_mute == 1'b1, "R6 not allowed ignored", {31'b0, in_mute}, 32'h1);
    send_byte(8'hEF, 1'b1, "R3 data ack");
    model_apply(8'hEF);
    chk(in_mute == 1'b0, "R6 mux active", {31'b0, in_mute}, 32'h0);
    bus_stop();
    chk_outputs("R6 final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog got=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule